// File: doc/BRIEF.md
# Triggered Programmable Interval Generator

This block turns an asynchronous trigger into one clean output pulse whose length is a programmable number of ticks. The trigger is synchronised into the clock domain and reduced to a single-cycle rising-edge event. That event arms an output register. The output register then lets a binary counter run. While the output is idle, the output register holds that counter at zero.

The width is set by two run-time controls. A tap select picks which counter bit ends the pulse, so the width is a power of two ticks. A tick-enable input decides on which clock cycles the counter may advance, which scales the effective count rate without a second clock domain. The pulse ends on the same clock edge that applies the tick that first sets the chosen bit. A busy flag follows the pulse so that a controller can tell when a new trigger will be accepted.

Top module: `ivg_interval_gen`

## Requirements
- R1: After a synchronous reset, `pulse_out` and `busy` are both low.
- R2: A trigger rise that is set up before a clock edge E1 drives `pulse_out` high after edge E4 (two synchroniser stages, the edge-capture register, then the output register), and not earlier.
- R3: With `tick_en` held high, the pulse stays high for exactly 2^k clock cycles, where k is the tap value latched at pulse start.
- R4: The counter advances only on edges where `tick_en` is high. The pulse therefore covers exactly 2^k tick-enabled edges and falls on the edge that applies the 2^k-th one. With `tick_en` low, the pulse holds for any length of time.
- R5: A tap select value above 13 (the top bit of the 14-bit counter) is treated as 13, which gives 8192 ticks.
- R6: The tap select is sampled when the pulse starts. Changing it during the pulse does not change that pulse's width.
- R7: A trigger rise whose event arrives while the pulse is high is dropped. It neither lengthens the pulse nor starts a later one.
- R8: A trigger that is held high produces only one pulse.
- R9: `busy` equals `pulse_out` on every cycle.
- R10: While idle, the counter is held at zero, so a pulse that follows another at once still gets its full width.
- R11: Asserting reset during a pulse drives `pulse_out` low after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interval clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Asynchronous trigger; the rising edge counts |
| tick_en | input | 1 | Count enable; the counter advances only when high |
| tap_sel | input | 4 | Counter bit that ends the pulse (0..13, larger values clamp to 13) |
| pulse_out | output | 1 | Interval pulse, active high |
| busy | output | 1 | High while a pulse is in progress |

## Verification
The bench measures widths at the very ends of the tap range: tap 0 must give a one-cycle pulse, and tap 13 and an out-of-range tap must both give 8192 cycles. An off-by-one in the terminal compare would show up as a pulse one tick long or short, and a design that does not clamp the tap would index past the counter and never end the pulse. It sends trigger edges while a pulse is running, holds the trigger high, and changes the tap mid-pulse. A design without edge detection would fire again after each pulse, and one without the tap latch would cut the pulse short. It also stalls the tick enable for a long stretch in mid-pulse and starts a second pulse right after the first. These catch a counter that runs freely or keeps a residue between pulses.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
  localparam int unsigned IVG_CNT_W       = 14;
  localparam int unsigned IVG_SYNC_STAGES = 2;
endpackage

// File: rtl/ivg_trig_sync.sv
module ivg_trig_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_async,
  output logic trig_evt
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], trig_async};
      prev_q <= sync_q[MSB];
      evt_q  <= sync_q[MSB] & ~prev_q;
    end
  end

  assign trig_evt = evt_q;

  // A held trigger must give a single-cycle event.
  assert_evt_single_R8: assert property (@(posedge clk) disable iff (rst)
    evt_q |=> !evt_q);
endmodule

// File: rtl/ivg_tick_counter.sv
module ivg_tick_counter #(
  parameter int unsigned CNT_W = 14,
  localparam int unsigned TAP_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick_en,
  input  logic [TAP_W-1:0] tap,
  output logic             term
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + 1'b1;
  assign term    = run & tick_en & cnt_nxt[tap];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !tick_en) |=> $stable(cnt_q));
endmodule

// File: rtl/ivg_pulse_ctl.sv
module ivg_pulse_ctl #(
  parameter int unsigned CNT_W = 14,
  localparam int unsigned TAP_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             term,
  input  logic [TAP_W-1:0] tap_in,
  output logic             pulse,
  output logic [TAP_W-1:0] tap_q
);
  localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(CNT_W - 1);

  logic [TAP_W-1:0] tap_clamped;
  logic             pulse_q;

  assign tap_clamped = (tap_in > TAP_MAX) ? TAP_MAX : tap_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      tap_q   <= '0;
    end else if (!pulse_q) begin
      if (evt) begin
        pulse_q <= 1'b1;
        tap_q   <= tap_clamped;
      end
    end else if (term) begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse = pulse_q;

  assert_start_from_evt_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> $past(evt));

  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && !term) |=> pulse_q);

  assert_end_on_term_R4: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && term) |=> !pulse_q);

  assert_tap_stable_R6: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> (!pulse_q || $stable(tap_q)));

  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> !pulse_q);
endmodule

// File: rtl/ivg_interval_gen.sv
module ivg_interval_gen
  import ivg_pkg::*;
#(
  parameter int unsigned CNT_W       = IVG_CNT_W,
  parameter int unsigned SYNC_STAGES = IVG_SYNC_STAGES,
  localparam int unsigned TAP_W      = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic             tick_en,
  input  logic [TAP_W-1:0] tap_sel,
  output logic             pulse_out,
  output logic             busy
);
  logic             trig_evt;
  logic             term;
  logic             pulse;
  logic [TAP_W-1:0] tap_q;

  ivg_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .trig_async (trig_in),
    .trig_evt   (trig_evt)
  );

  ivg_pulse_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .evt    (trig_evt),
    .term   (term),
    .tap_in (tap_sel),
    .pulse  (pulse),
    .tap_q  (tap_q)
  );

  ivg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (pulse),
    .tick_en (tick_en),
    .tap     (tap_q),
    .term    (term)
  );

  assign pulse_out = pulse;
  assign busy      = pulse;
endmodule

// File: tb/ivg_interval_gen_tb.sv
module ivg_interval_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig_in = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] tap_sel = 4'd0;
  logic       pulse_out;
  logic       busy;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_period = 1;
  int phase = 0;
  int cur_cyc = 0, cur_ticks = 0;
  int last_width = 0, last_ticks = 0, n_pulses = 0;
  int busy_mismatch = 0;
  int cyc_count = 0;
  logic p_prev = 1'b0;
  logic p_now = 1'b0;

  ivg_interval_gen u_dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .tick_en(tick_en),
    .tap_sel(tap_sel), .pulse_out(pulse_out), .busy(busy)
  );

  always #10 clk = ~clk;

  localparam int VEC_N = 9;
  localparam logic [3:0] V_TAP [VEC_N] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd7, 4'd2, 4'd4, 4'd13, 4'd15};
  localparam int         V_PER [VEC_N] = '{1, 1, 1, 1, 1, 3, 2, 1, 1};

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_count++;
      if (cyc_count > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc_count);
        report();
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: sample outputs at the falling edge, set the tick for the next rising edge.
  task automatic step;
    @(negedge clk);
    p_now = pulse_out;
    if (busy !== pulse_out) busy_mismatch++;
    phase++;
    tick_en = (tick_period == 0) ? 1'b0 : ((phase % tick_period) == 0);
    if (p_now === 1'b1) begin
      cur_cyc++;
      if (tick_en) cur_ticks++;
    end else if (p_prev === 1'b1) begin
      last_width = cur_cyc; last_ticks = cur_ticks; n_pulses++;
      cur_cyc = 0; cur_ticks = 0;
    end
    p_prev = p_now;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic fire;
    trig_in = 1'b1; step(); step(); trig_in = 1'b0;
  endtask

  task automatic wait_done(input int prev_n);
    for (int i = 0; i < 20000 && n_pulses == prev_n; i++) step();
  endtask

  function automatic int exp_ticks(input logic [3:0] t);
    return 1 << ((t > 4'd13) ? 13 : int'(t));
  endfunction

  initial begin
    int n0;
    steps(5);
    check(pulse_out === 1'b0 && busy === 1'b0, "R1 reset idle", int'(pulse_out), 0);
    rst = 1'b0;
    steps(3);

    // Table-driven widths
    for (int v = 0; v < VEC_N; v++) begin
      tap_sel = V_TAP[v];
      tick_period = V_PER[v];
      n0 = n_pulses;
      fire();
      wait_done(n0);
      check(last_ticks == exp_ticks(V_TAP[v]),
            (V_TAP[v] > 4'd13) ? "R5 clamped tap ticks" : "R4 ticks per pulse",
            last_ticks, exp_ticks(V_TAP[v]));
      if (V_PER[v] == 1)
        check(last_width == exp_ticks(V_TAP[v]), "R3 width in cycles", last_width, exp_ticks(V_TAP[v]));
      steps(5);
    end
    tick_period = 1;

    // R2 latency: trigger set at a falling edge, pulse seen after the 4th rising edge
    tap_sel = 4'd3;
    n0 = n_pulses;
    trig_in = 1'b1;
    step(); check(p_now === 1'b0, "R2 latency edge1", int'(p_now), 0);
    step(); check(p_now === 1'b0, "R2 latency edge2", int'(p_now), 0);
    trig_in = 1'b0;
    step(); check(p_now === 1'b0, "R2 latency edge3", int'(p_now), 0);
    step(); check(p_now === 1'b1, "R2 latency edge4", int'(p_now), 1);
    wait_done(n0);
    steps(5);

    // R4 tick stall mid-pulse
    tap_sel = 4'd3;
    n0 = n_pulses;
    fire();
    for (int i = 0; i < 10 && p_now !== 1'b1; i++) step();
    tick_period = 0;
    steps(40);
    check(p_now === 1'b1, "R4 hold while tick low", int'(p_now), 1);
    tick_period = 1;
    wait_done(n0);
    check(last_ticks == 8, "R4 stalled pulse ticks", last_ticks, 8);
    steps(5);

    // R7 retrigger during pulse ignored
    tap_sel = 4'd4;
    n0 = n_pulses;
    fire();
    for (int i = 0; i < 10 && p_now !== 1'b1; i++) step();
    steps(2);
    fire();
    wait_done(n0);
    check(last_width == 16, "R7 width unchanged by retrigger", last_width, 16);
    steps(20);
    check(n_pulses == n0 + 1, "R7 no extra pulse", n_pulses - n0, 1);

    // R8 held trigger
    tap_sel = 4'd2;
    n0 = n_pulses;
    trig_in = 1'b1;
    steps(60);
    check(n_pulses == n0 + 1, "R8 held trigger one pulse", n_pulses - n0, 1);
    trig_in = 1'b0;
    steps(5);

    // R6 tap changed mid-pulse
    tap_sel = 4'd5;
    n0 = n_pulses;
    fire();
    for (int i = 0; i < 10 && p_now !== 1'b1; i++) step();
    steps(3);
    tap_sel = 4'd1;
    wait_done(n0);
    check(last_width == 32, "R6 tap latched at start", last_width, 32);
    steps(5);

    // R10 back-to-back pulses
    tap_sel = 4'd3;
    n0 = n_pulses;
    fire();
    wait_done(n0);
    fire();
    wait_done(n0 + 1);
    check(last_width == 8, "R10 second pulse full width", last_width, 8);
    steps(5);

    // R11 reset during a pulse
    tap_sel = 4'd6;
    fire();
    for (int i = 0; i < 10 && p_now !== 1'b1; i++) step();
    steps(5);
    rst = 1'b1;
    step();
    step();
    check(p_now === 1'b0, "R11 reset ends pulse", int'(p_now), 0);
    rst = 1'b0;
    steps(3);

    check(busy_mismatch == 0, "R9 busy mirrors pulse", busy_mismatch, 0);
    report();
  end
endmodule